// File: doc/BRIEF.md
# Boot ROM Shadowing Memory Map Controller

This block is the address-decode glue for a processor with a 16-bit address and an 8-bit bank byte. Out of reset the slow boot ROM answers reads in the upper half of bank zero, so the processor can start running from it. The startup code reads each ROM location and writes it back to the same address. Writes in that range always reach the RAM underneath, so this loop fills RAM with a copy of the ROM.

When the copy is done, software sets an unmap flag in a small control register. From the next cycle on, reads of the range go to RAM, which runs at full speed. The flag stays set until reset.

A second control flag write-protects the top 1 KiB of bank zero, where interrupt entry stubs and vectors live. RAM write enable is withheld there, while reads of the range work as usual. A third flag locks the protect flag so that stray code cannot clear it.

One 256-byte page of bank zero is left to I/O devices and selects no memory. Every other address selects RAM. The chip-select outputs are combinational from the address, bank and direction inputs. Only the control flags are registered.

Top module: `mm_shadow_map`

## Requirements
- R1: After a synchronous reset all three control flags are clear. A read (cpu_rd=1) of bank 0x00, addresses 0x8000 to 0xFFFF, gives rom_sel=1, ram_sel=0 and ram_wr_en=0.
- R2: While the ROM is mapped, a write (cpu_rd=0) to bank 0x00, addresses 0x8000 to 0xFFFF, gives rom_sel=0, ram_sel=1 and ram_wr_en=1. This holds unless R5 blocks the write. rom_sel is never 1 during a write.
- R3: A cycle with cfg_wr=1 and cfg_wdata bit 0 set unmaps the ROM from the following cycle on. Reads of the ROM range then give ram_sel=1 and rom_sel=0.
- R4: Once set, the unmap flag stays set when control writes carry bit 0 clear. Only reset clears it.
- R5: A control write loads the write-protect flag from cfg_wdata bit 1. While that flag is set, a write to bank 0x00, 0xFC00 to 0xFFFF, gives ram_wr_en=0. Reads there still select as usual, and ram_sel stays 1 on a blocked write once unmapped.
- R6: The write protection covers only the protected region. Address 0x00FBFF and address 0xFC00 in any nonzero bank stay writable.
- R7: A control write with cfg_wdata bit 2 set sets the lock flag. Only reset clears it. While it is set, control writes leave the write-protect flag unchanged.
- R8: Accesses to bank 0x00, addresses 0x7F00 to 0x7FFF, give rom_sel=0, ram_sel=0 and ram_wr_en=0 in every state.
- R9: Any other address outside the ROM range and the I/O page gives ram_sel=1, rom_sel=0 and ram_wr_en equal to !cpu_rd. This includes every nonzero bank.
- R10: rom_sel and ram_sel are never 1 together. ram_wr_en is 1 only when ram_sel is 1 and cpu_rd is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address within the bank |
| cpu_bank | input | 8 | Processor bank byte |
| cpu_rd | input | 1 | 1 for a read cycle, 0 for a write cycle |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control data: bit 0 unmap, bit 1 write protect, bit 2 lock |
| rom_sel | output | 1 | Boot ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| ram_wr_en | output | 1 | RAM write enable |

## Verification
The hardest state to reach is a locked protect flag that software then tries to clear. It needs a sequence of control writes in a set order, and its effect shows only on writes to the vector region. The bench steps through phases: mapped, then unmapped, then protected, then locked. In each phase it sends a burst of random accesses that are weighted toward the region edges (0x7EFF/0x7F00, 0x7FFF/0x8000, 0xFBFF/0xFC00, 0xFFFF) and toward nonzero banks. Between bursts it sends control writes that try to undo the sticky flags. A reset partway through the run shows that only reset returns the ROM and releases the lock.

// File: rtl/mm_pkg.sv
package mm_pkg;

    // Control word bit positions; software depends on these
    localparam int CTL_W         = 3;
    localparam int CTL_UNMAP_BIT = 0;
    localparam int CTL_WP_BIT    = 1;
    localparam int CTL_LOCK_BIT  = 2;

    typedef struct packed {
        logic lock;
        logic wp;
        logic unmap;
    } ctrl_t;

    typedef struct packed {
        logic rom_rng;
        logic io_pg;
        logic vec_rng;
    } region_t;

    typedef struct packed {
        logic rom_sel;
        logic ram_sel;
        logic ram_we;
    } sel_t;

    // Next control state from current state and a control write word
    function automatic ctrl_t ctrl_next(ctrl_t cur, logic [CTL_W-1:0] d);
        ctrl_t n;
        n.unmap = cur.unmap | d[CTL_UNMAP_BIT];
        n.lock  = cur.lock  | d[CTL_LOCK_BIT];
        n.wp    = cur.lock ? cur.wp : d[CTL_WP_BIT];
        return n;
    endfunction

    // Chip selects from region flags, direction and control state
    function automatic sel_t select(region_t r, logic rd, ctrl_t c);
        sel_t s;
        s.rom_sel = r.rom_rng & rd & ~c.unmap;
        s.ram_sel = ~s.rom_sel & ~r.io_pg;
        s.ram_we  = s.ram_sel & ~rd & ~(c.wp & r.vec_rng);
        return s;
    endfunction

endpackage

// File: rtl/mm_ctrl_reg.sv
module mm_ctrl_reg
    import mm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctrl_t            ctrl
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr)
            ctrl_q <= ctrl_next(ctrl_q, wdata);
    end

    assign ctrl = ctrl_q;

    // R4: unmap is sticky until reset
    a_r4_unmap_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.unmap |=> ctrl_q.unmap);

    // R7: lock is sticky and freezes write protect
    a_r7_lock_freezes_wp: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> (ctrl_q.lock && $stable(ctrl_q.wp)));

    // R3: a control write with the unmap bit set unmaps next cycle
    a_r3_unmap_takes: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[CTL_UNMAP_BIT]) |=> ctrl_q.unmap);

endmodule

// File: rtl/mm_region_dec.sv
module mm_region_dec
    import mm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter int PAGE_W = 8,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFC00,
    parameter logic [ADDR_W-PAGE_W-1:0] IO_PAGE = 8'h7F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output region_t           region
);

    localparam int HI_W = ADDR_W - PAGE_W;

    logic             bank_zero;
    logic [HI_W-1:0]  page_no;

    assign bank_zero = (bank == '0);
    assign page_no   = addr[ADDR_W-1:PAGE_W];

    always_comb begin
        region         = '0;
        region.rom_rng = bank_zero && (addr >= ROM_BASE);
        region.vec_rng = bank_zero && (addr >= VEC_BASE);
        region.io_pg   = bank_zero && (page_no == IO_PAGE);
    end

endmodule

// File: rtl/mm_select.sv
module mm_select
    import mm_pkg::*;
(
    input  region_t region,
    input  logic    rd,
    input  ctrl_t   ctrl,
    output sel_t    sel
);

    assign sel = select(region, rd, ctrl);

endmodule

// File: rtl/mm_shadow_map.sv
module mm_shadow_map
    import mm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFC00,
    parameter logic [ADDR_W-9:0] IO_PAGE  = 8'h7F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0] cpu_bank,
    input  logic             cpu_rd,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_wdata,
    output logic             rom_sel,
    output logic             ram_sel,
    output logic             ram_wr_en
);

    ctrl_t   ctrl;
    region_t region;
    sel_t    sel;

    mm_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .ctrl  (ctrl)
    );

    mm_region_dec #(
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .PAGE_W   (8),
        .ROM_BASE (ROM_BASE),
        .VEC_BASE (VEC_BASE),
        .IO_PAGE  (IO_PAGE)
    ) u_dec (
        .addr   (cpu_addr),
        .bank   (cpu_bank),
        .region (region)
    );

    mm_select u_sel (
        .region (region),
        .rd     (cpu_rd),
        .ctrl   (ctrl),
        .sel    (sel)
    );

    assign rom_sel   = sel.rom_sel;
    assign ram_sel   = sel.ram_sel;
    assign ram_wr_en = sel.ram_we;

    // R10: selects are exclusive, write enable only with RAM write
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel && ram_sel));
    a_r10_we_qualified: assert property (@(posedge clk) disable iff (rst)
        ram_wr_en |-> (ram_sel && !cpu_rd));

    // R2: the ROM is never selected on a write
    a_r2_rom_never_written: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |-> !rom_sel);

    // R8: the I/O page selects no memory
    a_r8_io_quiet: assert property (@(posedge clk) disable iff (rst)
        region.io_pg |-> (!rom_sel && !ram_sel && !ram_wr_en));

    // R5: protected vector writes never reach RAM
    a_r5_vec_blocked: assert property (@(posedge clk) disable iff (rst)
        (ctrl.wp && region.vec_rng) |-> !ram_wr_en);

    // R9: outside bank zero only RAM is selected
    a_r9_upper_banks_ram: assert property (@(posedge clk) disable iff (rst)
        (cpu_bank != '0) |-> (ram_sel && !rom_sel));

endmodule

// File: tb/mm_shadow_map_tb_top.sv
module mm_shadow_map_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_bank;
    logic        cpu_rd;
    logic        cfg_wr;
    logic [2:0]  cfg_wdata;
    logic        rom_sel, ram_sel, ram_wr_en;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of the control flags
    logic m_unmap, m_wp, m_lock;

    always #2 clk = ~clk;

    mm_shadow_map dut_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_bank  (cpu_bank),
        .cpu_rd    (cpu_rd),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .rom_sel   (rom_sel),
        .ram_sel   (ram_sel),
        .ram_wr_en (ram_wr_en)
    );

    function automatic logic [2:0] expect_sel(logic [7:0] b, logic [15:0] a, logic rd);
        logic in_rom, in_io, in_vec, rs, ms, we;
        in_rom = (b == 8'h00) && (a >= 16'h8000);
        in_io  = (b == 8'h00) && (a[15:8] == 8'h7F);
        in_vec = (b == 8'h00) && (a >= 16'hFC00);
        rs = in_rom && rd && !m_unmap;
        ms = !rs && !in_io;
        we = ms && !rd && !(m_wp && in_vec);
        return {rs, ms, we};
    endfunction

    function automatic string tag_of(logic [7:0] b, logic [15:0] a, logic rd);
        if (b == 8'h00 && a[15:8] == 8'h7F)  return "R8";
        if (b == 8'h00 && a >= 16'hFC00 && m_wp) return "R5";
        if (b != 8'h00 && a >= 16'hFC00 && m_wp) return "R6";
        if (b == 8'h00 && a >= 16'h8000)
            return rd ? (m_unmap ? "R3" : "R1") : "R2";
        return "R9";
    endfunction

    task automatic access(input logic [7:0] b, input logic [15:0] a, input logic rd,
                          input string tag);
        logic [2:0] exp_v;
        @(negedge clk);
        cpu_bank = b; cpu_addr = a; cpu_rd = rd;
        #1;
        exp_v = expect_sel(b, a, rd);
        n_checks++;
        if ({rom_sel, ram_sel, ram_wr_en} !== exp_v) begin
            n_fail++;
            $display("FAIL %s bank=%02h addr=%04h rd=%0b actual rom/ram/we=%03b expected=%03b",
                     tag, b, a, rd, {rom_sel, ram_sel, ram_wr_en}, exp_v);
        end
        // R10 invariant at every sample
        n_checks++;
        if ((rom_sel && ram_sel) || (ram_wr_en && (!ram_sel || rd))) begin
            n_fail++;
            $display("FAIL R10 actual rom/ram/we=%03b expected exclusive and qualified",
                     {rom_sel, ram_sel, ram_wr_en});
        end
    endtask

    task automatic cfg_write(input logic [2:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
        m_unmap = m_unmap | d[0];
        if (!m_lock) m_wp = d[1];
        m_lock = m_lock | d[2];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_unmap = 0; m_wp = 0; m_lock = 0;
    endtask

    function automatic logic [15:0] pick_addr(int sel);
        case (sel % 10)
            0: return 16'h7EFF;
            1: return 16'h7F00 + 16'($urandom_range(0, 255));
            2: return 16'h7FFF + 16'($urandom_range(0, 1));
            3: return 16'hFBFF + 16'($urandom_range(0, 1));
            4: return 16'hFFFF;
            5: return 16'hFC00 + 16'($urandom_range(0, 16'h3FF));
            6: return 16'h8000 + 16'($urandom_range(0, 16'h7BFF));
            default: return 16'($urandom());
        endcase
    endfunction

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0]  b;
            logic [15:0] a;
            logic        rd;
            b  = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(1, 255)) : 8'h00;
            a  = pick_addr(int'($urandom_range(0, 99)));
            rd = 1'($urandom());
            access(b, a, rd, tag_of(b, a, rd));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cpu_addr = '0; cpu_bank = '0; cpu_rd = 1'b1;
        cfg_wr = 1'b0; cfg_wdata = '0;
        m_unmap = 0; m_wp = 0; m_lock = 0;
        do_reset();

        // R1 reset state: ROM answers reads of its range
        access(8'h00, 16'h8000, 1'b1, "R1");
        access(8'h00, 16'hFFFC, 1'b1, "R1");
        // R2 writes through to RAM while mapped
        access(8'h00, 16'h8000, 1'b0, "R2");
        access(8'h00, 16'hFFFF, 1'b0, "R2");
        // R8 I/O page
        access(8'h00, 16'h7F00, 1'b1, "R8");
        access(8'h00, 16'h7FFF, 1'b0, "R8");
        // R9 ordinary RAM
        access(8'h00, 16'h0000, 1'b0, "R9");
        access(8'h05, 16'h9000, 1'b1, "R9");
        burst(300);

        // R3 unmap
        cfg_write(3'b001);
        access(8'h00, 16'h8000, 1'b1, "R3");
        access(8'h00, 16'hFFFE, 1'b1, "R3");
        // R4 writing zero does not remap
        cfg_write(3'b000);
        access(8'h00, 16'hC000, 1'b1, "R4");
        burst(300);

        // R5 protect on
        cfg_write(3'b010);
        access(8'h00, 16'hFC00, 1'b0, "R5");
        access(8'h00, 16'hFFFF, 1'b0, "R5");
        access(8'h00, 16'hFC00, 1'b1, "R5");
        // R6 edges stay writable
        access(8'h00, 16'hFBFF, 1'b0, "R6");
        access(8'h01, 16'hFC00, 1'b0, "R6");
        burst(300);
        // protect off again (unlocked)
        cfg_write(3'b000);
        access(8'h00, 16'hFFFA, 1'b0, "R5");

        // R7 lock with protect set, then try to clear
        cfg_write(3'b110);
        cfg_write(3'b000);
        access(8'h00, 16'hFFFA, 1'b0, "R7");
        cfg_write(3'b000);
        access(8'h00, 16'hFC10, 1'b0, "R7");
        burst(300);

        // reset restores ROM mapping and releases lock (R1, R4, R7)
        do_reset();
        access(8'h00, 16'hFFFC, 1'b1, "R4");
        access(8'h00, 16'hFFFA, 1'b0, "R7");

        // R7 lock with protect clear keeps it clear
        cfg_write(3'b100);
        cfg_write(3'b010);
        access(8'h00, 16'hFFFE, 1'b0, "R7");
        burst(300);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule